// File: doc/BRIEF.md
# Two-Word Burst DDR SRAM Controller

This block sits between an on-chip request port and a synchronous double-data-rate SRAM that always moves two words per access. The user side offers one read or write per handshake, with a start address and, for a write, both data words. The controller turns each accepted request into a single memory command. The command is held for one full memory cycle that begins in the rising half of the memory clock. The controller then drives or collects the two data words at the half-cycle slots the memory expects.

The design runs on a clock at twice the memory clock rate, so each tick is one half-cycle slot. The `mem_kphase` output marks the slot in which the memory clock rises. The block keeps a slot-by-slot reservation of the data bus, which lets several short bursts overlap in flight. A request is refused while its burst would collide with one already scheduled. A request is also refused while it would turn the bus around with no idle half-cycle between a write burst and a read burst. Read data is collected only in slots that follow a raised valid-data flag. Each pair of collected words goes back to the user side in request order.

A static configuration input selects between the normal read latency of 2.5 memory cycles and a reduced latency of 1.0 cycle. The reduced latency is for a memory running with its internal clock alignment switched off. This input may only change while no burst is in flight.

Top module: `ddr2b_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request pending, `mem_ld_n` is 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: `mem_kphase` is 1 in every second slot, starting with the first slot after reset. `mem_ld_n`, `mem_rw` and `mem_addr` change only when a slot with `mem_kphase` = 1 begins, and are then held for two slots. `mem_ld_n` = 0 issues a command: `mem_rw` = 1 is a read and `mem_rw` = 0 is a write. `mem_ld_n` = 1 is a no-operation.
- R3: For a write whose command starts in slot T, `mem_dq_oe` is 1 in slots T+2 and T+3 only. `mem_dq_out` carries `req_wdata0` in slot T+2, for address A, and `req_wdata1` in slot T+3, for address A+1, which wraps within the address width.
- R4: With `cfg_short_lat` = 0, read words are expected in slots T+5 and T+6. `rsp_valid` then rises 8 slots after the slot in which the request was accepted.
- R5: With `cfg_short_lat` = 1, read words are expected in slots T+2 and T+3. `rsp_valid` then rises 5 slots after the acceptance slot.
- R6: A word on `mem_dq_in` is taken only in a slot that directly follows a slot with `mem_qvld` = 1. The words are taken in pairs: first word, then second word. Data present without the flag has no effect on any response.
- R7: `req_ready` is 1 only in slots with `mem_kphase` = 0, and only when the new burst's two slots are free. Two writes, or two reads, may be accepted 2 slots apart.
- R8: Bursts in opposite directions are kept at least one idle slot apart. A write followed by a read is accepted 2 slots apart in normal mode and 4 slots apart in reduced mode. A read followed by a write is accepted 6 slots apart in normal mode and 4 slots apart in reduced mode.
- R9: Each accepted read gives exactly one `rsp_valid` pulse, in acceptance order. `rsp_rdata0` holds the word at A and `rsp_rdata1` the word at A+1, as left by all writes accepted before that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Half-cycle clock, twice the memory clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_short_lat | input | 1 | 1 selects 1.0-cycle read latency, 0 selects 2.5 cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted in this slot when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Burst start address |
| req_wdata0 | input | DW | Write word for the start address |
| req_wdata1 | input | DW | Write word for the next address |
| rsp_valid | output | 1 | One-slot pulse with a read result |
| rsp_rdata0 | output | DW | Read word from the start address |
| rsp_rdata1 | output | DW | Read word from the next address |
| mem_kphase | output | 1 | 1 in the slot where the memory clock rises |
| mem_ld_n | output | 1 | Active-low command load strobe |
| mem_rw | output | 1 | 1 read, 0 write |
| mem_addr | output | AW | Command address |
| mem_dq_out | output | DW | Write data toward the memory |
| mem_dq_oe | output | 1 | Data bus driven by the controller |
| mem_dq_in | input | DW | Read data from the memory |
| mem_qvld | input | 1 | Read data valid flag, one slot ahead of each word |

## Verification
A wrong reservation bit shows at the ports within a few slots. The effect is either a spacing between accepted requests that differs from the stated values, or `mem_dq_oe` raised or dropped in a slot where the memory does not expect write data. Such a bit may also let a read window touch a write slot, which the bus monitor flags in that same half-cycle. A slip in the capture pairing swaps or shifts the returned words, and the next `rsp_valid` pulse shows a data mismatch. A phase or latency error moves the response away from its fixed distance of 8 or 5 slots after acceptance.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;
    // Encoding of the read/write select driven toward the memory
    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;
endpackage

// File: rtl/ddr2b_sched.sv
// Slot reservation of the shared data bus and the write data pipe.
// Bit i of a reservation vector stands for the slot i ticks from now.
module ddr2b_sched #(
    parameter int DW            = 18,
    parameter int WR_HALF       = 2,
    parameter int RD_HALF_NORM  = 5,
    parameter int RD_HALF_SHORT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_slot_i,
    input  logic          cfg_short_i,
    input  logic          req_valid_i,
    input  logic          req_write_i,
    input  logic [DW-1:0] wdata0_i,
    input  logic [DW-1:0] wdata1_i,
    output logic          ready_o,
    output logic [DW-1:0] dq_out_o,
    output logic          dq_oe_o,
    output logic          rd_due_o
);
    localparam int RD_MAX  = (RD_HALF_NORM > RD_HALF_SHORT) ? RD_HALF_NORM : RD_HALF_SHORT;
    localparam int OFF_MAX = (RD_MAX > WR_HALF) ? RD_MAX : WR_HALF;
    localparam int RES_W   = OFF_MAX + 4;

    typedef struct packed {
        logic [RES_W-1:0]         wr_res;
        logic [RES_W-1:0]         rd_res;
        logic [RES_W-1:0][DW-1:0] wd;
    } sched_t;

    sched_t s_d, s_q;
    logic   clash;
    logic   same_b, opp_b;
    int     off;

    always_comb begin
        s_d        = s_q;
        s_d.wr_res = s_q.wr_res >> 1;
        s_d.rd_res = s_q.rd_res >> 1;
        for (int i = 0; i < RES_W - 1; i++) begin
            s_d.wd[i] = s_q.wd[i+1];
        end
        s_d.wd[RES_W-1] = '0;

        off = req_write_i ? WR_HALF : (cfg_short_i ? RD_HALF_SHORT : RD_HALF_NORM);

        // window of the new burst is off+1..off+2 from this slot,
        // the opposite direction also needs the neighbouring slots free
        clash  = 1'b0;
        same_b = 1'b0;
        opp_b  = 1'b0;
        for (int i = 0; i < RES_W; i++) begin
            same_b = req_write_i ? s_q.wr_res[i] : s_q.rd_res[i];
            opp_b  = req_write_i ? s_q.rd_res[i] : s_q.wr_res[i];
            if ((i == off + 1 || i == off + 2) && (same_b || opp_b)) begin
                clash = 1'b1;
            end
            if ((i == off || i == off + 3) && opp_b) begin
                clash = 1'b1;
            end
        end

        ready_o = issue_slot_i && !clash;

        if (ready_o && req_valid_i) begin
            for (int i = 0; i < RES_W; i++) begin
                if (req_write_i) begin
                    if (i == WR_HALF) begin
                        s_d.wr_res[i] = 1'b1;
                        s_d.wd[i]     = wdata0_i;
                    end
                    if (i == WR_HALF + 1) begin
                        s_d.wr_res[i] = 1'b1;
                        s_d.wd[i]     = wdata1_i;
                    end
                end else if (i == off || i == off + 1) begin
                    s_d.rd_res[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dq_oe_o  = s_q.wr_res[0];
    assign dq_out_o = s_q.wd[0];
    assign rd_due_o = s_q.rd_res[0];

    // R8: a driven slot never meets or touches an expected read slot
    assert_no_clash_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wr_res[0] |-> !(s_q.rd_res[0] || s_q.rd_res[1]));
    assert_no_clash_rd_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rd_res[0] |-> !s_q.wr_res[1]);
    // R3: a driven slot is followed by exactly one more driven slot of the same burst
    assert_wr_pair_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.wr_res[0])) |=> s_q.wr_res[0]);
endmodule

// File: rtl/ddr2b_capture.sv
// Collects read words behind the valid-data flag and pairs them.
module ddr2b_capture #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          qvld_i,
    input  logic [DW-1:0] dq_in_i,
    input  logic          rd_due_i,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_data0_o,
    output logic [DW-1:0] rsp_data1_o
);
    typedef struct packed {
        logic          flag;
        logic          second;
        logic          rv;
        logic [DW-1:0] hold0;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.flag = qvld_i;
        c_d.rv   = 1'b0;
        if (c_q.flag) begin
            if (!c_q.second) begin
                c_d.hold0  = dq_in_i;
                c_d.second = 1'b1;
            end else begin
                c_d.rv     = 1'b1;
                c_d.d0     = c_q.hold0;
                c_d.d1     = dq_in_i;
                c_d.second = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rsp_valid_o = c_q.rv;
    assign rsp_data0_o = c_q.d0;
    assign rsp_data1_o = c_q.d1;

    // R6: a flagged slot only ever lands on a slot the scheduler reserved for a read
    assert_capture_window_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        c_q.flag |-> rd_due_i);
    // R9: results leave as single-slot pulses
    assert_rsp_pulse_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: rtl/ddr2b_ctrl.sv
module ddr2b_ctrl #(
    parameter int AW            = 20,
    parameter int DW            = 18,
    parameter int WR_HALF       = 2,
    parameter int RD_HALF_NORM  = 5,
    parameter int RD_HALF_SHORT = 2
) (
    input  logic          clk2x,
    input  logic          rst_n,
    input  logic          cfg_short_lat,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata0,
    input  logic [DW-1:0] req_wdata1,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata0,
    output logic [DW-1:0] rsp_rdata1,
    output logic          mem_kphase,
    output logic          mem_ld_n,
    output logic          mem_rw,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in,
    input  logic          mem_qvld
);
    import ddr2b_pkg::*;

    typedef struct packed {
        logic          phase;
        logic          ld_n;
        logic          rw;
        logic [AW-1:0] addr;
    } ctrl_t;

    ctrl_t k_d, k_q;
    logic  issue_slot;
    logic  rd_due;
    logic  accept;

    // phase 1 is the half just before the memory clock rises
    assign issue_slot = k_q.phase;
    assign accept     = req_valid && req_ready;

    always_comb begin
        k_d       = k_q;
        k_d.phase = ~k_q.phase;
        if (issue_slot) begin
            k_d.ld_n = !accept;
            if (accept) begin
                k_d.rw   = req_write ? DIR_WRITE : DIR_READ;
                k_d.addr = req_addr;
            end
        end
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            k_q <= '{phase: 1'b0, ld_n: 1'b1, rw: DIR_READ, addr: '0};
        end else begin
            k_q <= k_d;
        end
    end

    assign mem_kphase = ~k_q.phase;
    assign mem_ld_n   = k_q.ld_n;
    assign mem_rw     = k_q.rw;
    assign mem_addr   = k_q.addr;

    ddr2b_sched #(
        .DW           (DW),
        .WR_HALF      (WR_HALF),
        .RD_HALF_NORM (RD_HALF_NORM),
        .RD_HALF_SHORT(RD_HALF_SHORT)
    ) u_sched (
        .clk         (clk2x),
        .rst_n       (rst_n),
        .issue_slot_i(issue_slot),
        .cfg_short_i (cfg_short_lat),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .wdata0_i    (req_wdata0),
        .wdata1_i    (req_wdata1),
        .ready_o     (req_ready),
        .dq_out_o    (mem_dq_out),
        .dq_oe_o     (mem_dq_oe),
        .rd_due_o    (rd_due)
    );

    ddr2b_capture #(
        .DW(DW)
    ) u_cap (
        .clk        (clk2x),
        .rst_n      (rst_n),
        .qvld_i     (mem_qvld),
        .dq_in_i    (mem_dq_in),
        .rd_due_i   (rd_due),
        .rsp_valid_o(rsp_valid),
        .rsp_data0_o(rsp_rdata0),
        .rsp_data1_o(rsp_rdata1)
    );

    // R2: a command starts only where the memory clock rises and lasts a full cycle
    assert_cmd_on_rise_R2 : assert property (@(posedge clk2x) disable iff (!rst_n)
        $fell(mem_ld_n) |-> mem_kphase);
    assert_cmd_held_R2 : assert property (@(posedge clk2x) disable iff (!rst_n)
        (!mem_ld_n && mem_kphase) |=> (!mem_ld_n && $stable(mem_addr) && $stable(mem_rw)));
    // R7: an accepted request shows up as the next command with its direction
    assert_accept_issues_R7 : assert property (@(posedge clk2x) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!mem_ld_n && mem_kphase && (mem_rw == !$past(req_write))));
    // R3: the first write word follows a write command by one memory cycle
    assert_wr_source_R3 : assert property (@(posedge clk2x) disable iff (!rst_n)
        (mem_dq_oe && mem_kphase) |-> $past(!mem_ld_n && !mem_rw && mem_kphase, 2));
endmodule

// File: tb/ddr2b_ctrl_tb.sv
module ddr2b_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;
    localparam int SCH   = 16;
    localparam int QN    = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_short_lat = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata0 = '0;
    logic [DW-1:0] req_wdata1 = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata0, rsp_rdata1;
    logic          mem_kphase, mem_ld_n, mem_rw, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;
    logic          mem_qvld = 1'b0;

    ddr2b_ctrl #(.AW(AW), .DW(DW)) u_dut (
        .clk2x(clk), .rst_n(rst_n), .cfg_short_lat(cfg_short_lat),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata0(req_wdata0), .req_wdata1(req_wdata1),
        .rsp_valid(rsp_valid), .rsp_rdata0(rsp_rdata0), .rsp_rdata1(rsp_rdata1),
        .mem_kphase(mem_kphase), .mem_ld_n(mem_ld_n), .mem_rw(mem_rw),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_qvld(mem_qvld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cnt = 0;
    int last_rsp_cnt = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // reference memory, updated in acceptance order
    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] exp0 [QN];
    logic [DW-1:0] exp1 [QN];
    int q_head = 0;
    int q_tail = 0;

    // memory responder state (index 0 = current slot)
    logic [DW-1:0] rmem [DEPTH];
    logic          qv [SCH];
    logic          rv [SCH];
    logic          wv [SCH];
    logic [AW-1:0] ra [SCH];
    logic [AW-1:0] wa [SCH];
    logic          rdrv_cur = 1'b0;

    // values of the controller outputs, taken mid-slot
    logic          s_ld_n = 1'b1, s_rw = 1'b1, s_oe = 1'b0, s_kph = 1'b0;
    logic [AW-1:0] s_addr = '0;
    logic [DW-1:0] s_dq = '0;
    logic          prev_oe = 1'b0, prev_rd = 1'b0, prev_ld_n = 1'b1;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = DW'(i * 37 + 5);
            rmem[i]    = DW'(i * 37 + 5);
        end
        for (int i = 0; i < SCH; i++) begin
            qv[i] = 1'b0; rv[i] = 1'b0; wv[i] = 1'b0; ra[i] = '0; wa[i] = '0;
        end
    end

    // memory responder
    always @(posedge clk) begin
        int lat;
        logic [AW-1:0] a1;
        if (!rst_n) begin
            for (int i = 0; i < SCH; i++) begin
                qv[i] = 1'b0; rv[i] = 1'b0; wv[i] = 1'b0;
            end
            mem_qvld <= 1'b0;
            rdrv_cur = 1'b0;
        end else begin
            if (s_oe || wv[0]) begin
                check(s_oe == wv[0], "R3", "write drive slot", s_oe, wv[0]);
            end
            if (wv[0]) rmem[wa[0]] = s_dq;
            if (s_kph && !s_ld_n) begin
                a1 = s_addr + 1'b1;
                if (!s_rw) begin
                    wv[2] = 1'b1; wa[2] = s_addr;
                    wv[3] = 1'b1; wa[3] = a1;
                end else begin
                    lat = cfg_short_lat ? 2 : 5;
                    qv[lat-1] = 1'b1; qv[lat] = 1'b1;
                    rv[lat] = 1'b1; ra[lat] = s_addr;
                    rv[lat+1] = 1'b1; ra[lat+1] = a1;
                end
            end
            for (int i = 0; i < SCH - 1; i++) begin
                qv[i] = qv[i+1]; rv[i] = rv[i+1]; wv[i] = wv[i+1];
                ra[i] = ra[i+1]; wa[i] = wa[i+1];
            end
            qv[SCH-1] = 1'b0; rv[SCH-1] = 1'b0; wv[SCH-1] = 1'b0;
            mem_qvld  <= qv[0];
            mem_dq_in <= rv[0] ? rmem[ra[0]] : (DW'(16'hBAD0) ^ DW'(cnt));
            rdrv_cur = rv[0];
        end
    end

    // mid-slot monitor
    always @(negedge clk) begin
        cnt++;
        s_ld_n = mem_ld_n; s_rw = mem_rw; s_addr = mem_addr;
        s_oe = mem_dq_oe; s_dq = mem_dq_out; s_kph = mem_kphase;
        if (rst_n) begin
            if (s_ld_n != prev_ld_n) begin
                check(s_kph, "R2", "strobe change outside rising half", s_kph, 1);
            end
            if (s_oe && rdrv_cur) check(0, "R8", "write and read data in one slot", 1, 0);
            if ((prev_oe && rdrv_cur) || (prev_rd && s_oe)) begin
                check(0, "R8", "no idle slot at turnaround", 1, 0);
            end
            if (rsp_valid) begin
                last_rsp_cnt = cnt;
                if (q_head == q_tail) begin
                    check(0, "R9", "response with no read pending", 1, 0);
                end else begin
                    check(rsp_rdata0 == exp0[q_head % QN], "R9", "first read word",
                          rsp_rdata0, exp0[q_head % QN]);
                    check(rsp_rdata1 == exp1[q_head % QN], "R9", "second read word",
                          rsp_rdata1, exp1[q_head % QN]);
                    q_head++;
                end
            end
        end
        prev_ld_n = s_ld_n;
        prev_oe   = s_oe;
        prev_rd   = rdrv_cur;
    end

    task automatic do_req(input bit wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                          output int acc);
        logic [AW-1:0] a1;
        a1 = a + 1'b1;
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_addr   = a;
        req_wdata0 = d0;
        req_wdata1 = d1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cnt;
        if (wr) begin
            ref_mem[a]  = d0;
            ref_mem[a1] = d1;
        end else begin
            exp0[q_tail % QN] = ref_mem[a];
            exp1[q_tail % QN] = ref_mem[a1];
            q_tail++;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (24) @(negedge clk);
    endtask

    task automatic run_mode(input bit short_m);
        int t0, t1;
        cfg_short_lat = short_m;
        drain();
        // R4 / R5: fixed read latency
        do_req(0, 6'd5, '0, '0, t0);
        drain();
        check(last_rsp_cnt - t0 == (short_m ? 5 : 8), short_m ? "R5" : "R4",
              "slots from accept to response", last_rsp_cnt - t0, short_m ? 5 : 8);
        // R8: write then read, read sees new data (R9)
        do_req(1, 6'd10, 16'h1111, 16'h2222, t0);
        do_req(0, 6'd10, '0, '0, t1);
        check(t1 - t0 == (short_m ? 4 : 2), "R8", "write to read spacing", t1 - t0, short_m ? 4 : 2);
        drain();
        // R8: read then write
        do_req(0, 6'd20, '0, '0, t0);
        do_req(1, 6'd20, 16'h3333, 16'h4444, t1);
        check(t1 - t0 == (short_m ? 4 : 6), "R8", "read to write spacing", t1 - t0, short_m ? 4 : 6);
        drain();
        // R7: same direction back to back
        do_req(1, 6'd30, 16'h5555, 16'h6666, t0);
        do_req(1, 6'd32, 16'h7777, 16'h8888, t1);
        check(t1 - t0 == 2, "R7", "write to write spacing", t1 - t0, 2);
        do_req(0, 6'd30, '0, '0, t0);
        do_req(0, 6'd31, '0, '0, t1);
        check(t1 - t0 == 2, "R7", "read to read spacing", t1 - t0, 2);
        check((t0 % 2) == (t1 % 2), "R7", "accept phase alignment", t1 % 2, t0 % 2);
        drain();
        // R3: address wrap of the second word
        do_req(1, 6'(DEPTH - 1), 16'hA5A5, 16'h5A5A, t0);
        do_req(0, 6'(DEPTH - 1), '0, '0, t1);
        do_req(0, 6'd0, '0, '0, t1);
        drain();
        // random mix
        for (int k = 0; k < 150; k++) begin
            bit wr;
            wr = ($urandom % 2) == 1;
            if (($urandom % 5) == 0) repeat ($urandom % 4) @(negedge clk);
            do_req(wr, AW'($urandom), DW'($urandom), DW'($urandom), t0);
        end
        drain();
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 during reset
        check(mem_ld_n == 1'b1, "R1", "strobe in reset", mem_ld_n, 1);
        check(mem_dq_oe == 1'b0, "R1", "bus drive in reset", mem_dq_oe, 0);
        check(rsp_valid == 1'b0, "R1", "response in reset", rsp_valid, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1;
            check(mem_ld_n == 1'b1 && mem_dq_oe == 1'b0 && rsp_valid == 1'b0, "R1",
                  "idle after reset", {mem_ld_n, mem_dq_oe, rsp_valid}, 3'b100);
        end
        run_mode(1'b0);
        run_mode(1'b1);
        run_mode(1'b0);
        check(q_head == q_tail, "R9", "reads left without response", q_tail - q_head, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end actual=%0d expected=%0d", cnt, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule